// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. A free-running 32-bit seconds count advances once every N+1 pulses of a slow reference tick. N is the divisor held in the low half of a regulator register. Software reaches the block over a plain register bus with an address, a write strobe, write data and combinational read data. Through it, software sets the time, arms a 32-bit alarm compare value, keeps a word in a scratchpad, and requests hibernation.

Every write goes through a small write gate. The gate models the hand-off into a slow time-keeping domain. It has two states. In `WG_READY` a write strobe is accepted, and the *accept* transition moves it to `WG_BUSY`. In `WG_BUSY` the ready bit reads 0 and further strobes are dropped. After `BUSY_CYCLES` cycles the *drain* transition returns it to `WG_READY`.

Two sticky flags can raise the interrupt line:
- a per-second flag, which sets on each seconds increment;
- an alarm flag, which sets when the armed alarm value first matches the count.

Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves it alone, so a read-modify-write cannot lose a pending event.

Top module: `sec_rtc_top`

## Requirements
- R1: After reset:
  - control reads 0x80, where bit 7 is write-ready = 1 and all other control bits are 0;
  - seconds, alarm and scratchpad read 0;
  - the regulator reads `DIV_RESET`;
  - `irq` and `hib_req` are 0.
- R2: An accepted write drops control bit 7 to 0 for exactly `BUSY_CYCLES` cycles, starting the cycle after the write. A write strobe issued while bit 7 is 0 changes no register.
- R3: While enabled (control bit 0), the seconds count (offset 0x04) increments on every (D+1)-th reference tick, where D is regulator bits 15:0 (offset 0x0C).
- R4: With control bit 0 clear, reference ticks change neither the seconds count nor the prescaler. A write to offset 0x04 loads the count and restarts the prescaler from zero.
- R5: The per-second flag (control bit 6) sets on every seconds increment.
- R6: Writing control with a 0 in a flag bit (bit 6 or bit 4) clears that flag. Writing a 1 there leaves the flag as it was. If a set event and a clearing write occur in the same cycle, the set wins.
- R7: With alarm enable (control bit 2) set, the alarm flag (control bit 4) sets in the cycle after the seconds count first equals the alarm value at offset 0x08. It does not set again until the match has gone away and then come back.
- R8: `irq` is high when (bit 6 and bit 5) or (bit 4 and bit 3) are both set in control.
- R9: The regulator keeps bits 25:16 (fine adjust) and bits 15:0 (divisor). Its other bits read 0.
- R10: The scratchpad (offset 0x34) and the alarm (offset 0x08) read back the full 32-bit value last written.
- R11: Writing a word with bit 0 set to offset 0x20 produces a one-cycle `hib_req` pulse in the cycle after the write. Offset 0x20 reads 0.
- R12: Any unmapped offset reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ref_tick | input | 1 | one-cycle pulse per slow reference clock edge |
| bus_addr | input | 8 | byte offset of the register |
| bus_we | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr` |
| irq | output | 1 | interrupt request |
| hib_req | output | 1 | hibernate request pulse |

## Verification
The hardest condition to reach from the ports is a strobe arriving while the write gate is in `WG_BUSY`. The normal write task always waits out the busy window, so that case never arises from it. The bench therefore issues a scratchpad write and, in the very next cycle, a second scratchpad write with a different value. It reads control bit 7 between the two strobes and the scratchpad once the gate has drained. A second hard case is the prescaler restart on a seconds load. The stimulus leaves the prescaler part-way through a period, loads the count, and then counts a full D+1 ticks before the next increment.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 16;
    localparam int ADJ_W  = 10;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SECS  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ALARM = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_REGUL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_HIBER = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_SCRAT = 8'h34;

    localparam int B_RDY  = 7;
    localparam int B_HZF  = 6;
    localparam int B_HZIE = 5;
    localparam int B_AF   = 4;
    localparam int B_AFIE = 3;
    localparam int B_AE   = 2;
    localparam int B_EN   = 0;

    localparam int ADJ_LSB = 16;

    typedef enum logic {
        WG_READY = 1'b0,
        WG_BUSY  = 1'b1
    } wg_state_t;
endpackage

// File: rtl/sec_rtc_wrgate.sv
module sec_rtc_wrgate
    import sec_rtc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    output logic accept,
    output logic ready
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

    wg_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WG_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            WG_READY: begin
                ready = 1'b1;
                if (we) begin
                    accept  = 1'b1;
                    state_d = WG_BUSY;
                    cnt_d   = '0;
                end
            end
            WG_BUSY: begin
                if (cnt_q == LAST) begin
                    state_d = WG_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = WG_READY;
        endcase
    end

    // R2: an accepted write closes the gate in the next cycle
    p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);
    // R2: a strobe is never accepted while the gate is closed
    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !accept);
endmodule

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale
    import sec_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    logic [DIV_W-1:0] cnt_q;

    assign step = run && ref_tick && !restart && (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && ref_tick) begin
            cnt_q <= step ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: a stopped prescaler keeps its count
    p_stopped_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter
    import sec_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    input  logic [DATA_W-1:0] alarm,
    input  logic              alarm_en,
    output logic [DATA_W-1:0] secs,
    output logic              alarm_hit
);
    logic [DATA_W-1:0] secs_q;
    logic              match_q;
    logic              match;

    assign match     = alarm_en && (secs_q == alarm);
    assign alarm_hit = match && !match_q;
    assign secs      = secs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secs_q  <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= match;
            if (load)
                secs_q <= load_val;
            else if (step)
                secs_q <= secs_q + 1'b1;
        end
    end

    // R4: without a load or a step the count is frozen
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(secs_q));
    // R3: a step without a load advances by one
    p_step_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (secs_q == $past(secs_q) + 1'b1));
endmodule

// File: rtl/sec_rtc_top.sv
module sec_rtc_top
    import sec_rtc_pkg::*;
#(
    parameter int               BUSY_CYCLES = 4,
    parameter logic [DIV_W-1:0] DIV_RESET   = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              hib_req
);
    logic accept, ready;
    logic wr_ctrl, wr_secs, wr_alarm, wr_regul, wr_hiber, wr_scrat;
    logic step, alarm_hit;
    logic [DATA_W-1:0] secs;

    logic              en_q, ae_q, afie_q, hzie_q, hzf_q, af_q, hib_q;
    logic [DATA_W-1:0] alarm_q, scrat_q;
    logic [DIV_W-1:0]  div_q;
    logic [ADJ_W-1:0]  adj_q;

    sec_rtc_wrgate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .accept(accept), .ready(ready)
    );

    assign wr_ctrl  = accept && (bus_addr == OFF_CTRL);
    assign wr_secs  = accept && (bus_addr == OFF_SECS);
    assign wr_alarm = accept && (bus_addr == OFF_ALARM);
    assign wr_regul = accept && (bus_addr == OFF_REGUL);
    assign wr_hiber = accept && (bus_addr == OFF_HIBER);
    assign wr_scrat = accept && (bus_addr == OFF_SCRAT);

    sec_rtc_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(en_q), .ref_tick(ref_tick),
        .restart(wr_secs), .div(div_q), .step(step)
    );

    sec_rtc_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .load(wr_secs), .load_val(bus_wdata),
        .step(step), .alarm(alarm_q), .alarm_en(ae_q),
        .secs(secs), .alarm_hit(alarm_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ae_q    <= 1'b0;
            afie_q  <= 1'b0;
            hzie_q  <= 1'b0;
            hzf_q   <= 1'b0;
            af_q    <= 1'b0;
            hib_q   <= 1'b0;
            alarm_q <= '0;
            scrat_q <= '0;
            div_q   <= DIV_RESET;
            adj_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= bus_wdata[B_EN];
                ae_q   <= bus_wdata[B_AE];
                afie_q <= bus_wdata[B_AFIE];
                hzie_q <= bus_wdata[B_HZIE];
            end
            if (step)
                hzf_q <= 1'b1;
            else if (wr_ctrl)
                hzf_q <= hzf_q & bus_wdata[B_HZF];
            if (alarm_hit)
                af_q <= 1'b1;
            else if (wr_ctrl)
                af_q <= af_q & bus_wdata[B_AF];
            if (wr_alarm)
                alarm_q <= bus_wdata;
            if (wr_scrat)
                scrat_q <= bus_wdata;
            if (wr_regul) begin
                div_q <= bus_wdata[DIV_W-1:0];
                adj_q <= bus_wdata[ADJ_LSB +: ADJ_W];
            end
            hib_q <= wr_hiber && bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[B_RDY]  = ready;
                bus_rdata[B_HZF]  = hzf_q;
                bus_rdata[B_HZIE] = hzie_q;
                bus_rdata[B_AF]   = af_q;
                bus_rdata[B_AFIE] = afie_q;
                bus_rdata[B_AE]   = ae_q;
                bus_rdata[B_EN]   = en_q;
            end
            OFF_SECS:  bus_rdata = secs;
            OFF_ALARM: bus_rdata = alarm_q;
            OFF_REGUL: begin
                bus_rdata[DIV_W-1:0]          = div_q;
                bus_rdata[ADJ_LSB +: ADJ_W]   = adj_q;
            end
            OFF_SCRAT: bus_rdata = scrat_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq     = (hzf_q && hzie_q) || (af_q && afie_q);
    assign hib_req = hib_q;

    // R11: the hibernate request lasts a single cycle
    p_hib_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hib_req |=> !hib_req);
    // R6: a control write with bit 6 clear drops the per-second flag
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[B_HZF] && !step) |=> !hzf_q);
    // R5: every increment leaves the per-second flag set
    p_hz_on_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> hzf_q);
    // R7: a new alarm flag only appears while alarm matching was enabled
    p_alarm_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af_q) |-> $past(ae_q));
endmodule

// File: tb/sim_sec_rtc_top.sv
module sim_sec_rtc_top;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, hib_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sec_rtc_top #(.BUSY_CYCLES(BUSY), .DIV_RESET(16'h7FFF)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .hib_req(hib_req)
    );

    // {offset, write data, expected read-back}
    localparam logic [71:0] VEC [7] = '{
        {8'h0C, 32'hFFFF_FFFF, 32'h03FF_FFFF},
        {8'h34, 32'h1234_5678, 32'h1234_5678},
        {8'h08, 32'hA5A5_0001, 32'hA5A5_0001},
        {8'h20, 32'h0000_0000, 32'h0000_0000},
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h04, 32'h0000_0050, 32'h0000_0050},
        {8'h00, 32'h0000_00FF, 32'h0000_00AD}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        repeat (BUSY) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h80);
        rd(8'h04, v); chk("R1 secs", v, 0);
        rd(8'h08, v); chk("R1 alarm", v, 0);
        rd(8'h34, v); chk("R1 scratch", v, 0);
        rd(8'h0C, v); chk("R1 regul", v, 32'h7FFF);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 hib", {31'd0, hib_req}, 0);

        // table: R9 R10 R11 R12 and control write-1 keeps flags clear (R6)
        foreach (VEC[i]) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R9/R10/R11/R12/R6 table", v, VEC[i][31:0]);
        end
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R1 ctrl cleared", v, 32'h80);

        // R2 busy window and dropped strobe
        bus_addr = 8'h34; bus_wdata = 32'hDEAD_0001; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h00, v); chk("R2 ready low", {31'd0, v[7]}, 0);
        bus_addr = 8'h34; bus_wdata = 32'h0000_0BAD; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        repeat (BUSY) @(negedge clk);
        rd(8'h00, v); chk("R2 ready back", {31'd0, v[7]}, 1);
        rd(8'h34, v); chk("R2 busy write ignored", v, 32'hDEAD_0001);

        // R3 prescaler, divisor 2 -> every third tick
        wr(8'h0C, 32'h2);
        wr(8'h04, 32'd10);
        wr(8'h00, 32'h21);
        tick(2);
        rd(8'h04, v); chk("R3 before period", v, 10);
        tick(1);
        rd(8'h04, v); chk("R3 increment", v, 11);
        rd(8'h00, v); chk("R5 hz flag", v, 32'hE1);
        chk("R8 irq hz", {31'd0, irq}, 1);
        wr(8'h00, 32'h61);
        rd(8'h00, v); chk("R6 write one keeps", v, 32'hE1);
        wr(8'h00, 32'h21);
        rd(8'h00, v); chk("R6 write zero clears", v, 32'hA1);
        chk("R8 irq cleared", {31'd0, irq}, 0);

        // R4 disable gating
        wr(8'h00, 32'h20);
        tick(5);
        rd(8'h04, v); chk("R4 disabled hold", v, 11);

        // R4 seconds load restarts the prescaler
        wr(8'h00, 32'h21);
        tick(1);
        wr(8'h04, 32'd20);
        tick(2);
        rd(8'h04, v); chk("R4 restart hold", v, 20);
        tick(1);
        rd(8'h04, v); chk("R4 restart step", v, 21);

        // R7 alarm
        wr(8'h08, 32'd23);
        wr(8'h00, 32'h0D);
        tick(3);
        rd(8'h00, v); chk("R7 no early alarm", {31'd0, v[4]}, 0);
        chk("R8 irq quiet", {31'd0, irq}, 0);
        tick(3);
        rd(8'h04, v); chk("R7 secs at alarm", v, 23);
        rd(8'h00, v); chk("R7 alarm flag", {31'd0, v[4]}, 1);
        chk("R8 irq alarm", {31'd0, irq}, 1);
        wr(8'h00, 32'h0D);
        rd(8'h00, v); chk("R7 no re-set while matching", {31'd0, v[4]}, 0);
        chk("R8 irq after clear", {31'd0, irq}, 0);

        // R11 hibernate pulse
        bus_addr = 8'h20; bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R11 hib pulse", {31'd0, hib_req}, 1);
        @(negedge clk);
        chk("R11 hib single", {31'd0, hib_req}, 0);
        repeat (BUSY) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule